// File: doc/BRIEF.md
# SCSI Bus Phase Monitor and Interrupt Collector

This block watches the control and data lines of a SCSI bus on behalf of a protocol controller. It has two jobs. It compares the live information-transfer phase with the phase that firmware expects, and it gathers several bus events into one level-sensitive interrupt line. Driving the bus and moving data are handled by other blocks. This one only observes the lines, latches conditions and reports them.

The watched events are:
- a phase disagreement seen at a REQ assertion while DMA is running;
- selection or reselection of this device;
- a parity error;
- BSY dropping;
- end of process from the DMA engine.

Each event is held in its own sticky flag. A flag reaches the interrupt only when its enable allows it. Firmware reads a status byte at one address and clears every latched flag by reading a second address. While a phase disagreement is latched, the DMA request towards the host is held off.

Top module: `scsi_evt_monitor`

## Requirements
- R1: After synchronous reset, every latched condition is clear and `irq` is low. With all bus inputs low and `exp_phase` at 000, the status byte reads 8'h08.
- R2: Status bit 3 is high exactly when the live phase equals `exp_phase`. The live phase is {MSG,C/D,I/O}, and `exp_phase` bit 2 is MSG, bit 1 is C/D and bit 0 is I/O. The phase codes are: data-out 000, data-in 001, command 010, status 011, message-out 110, message-in 111.
- R3: A phase disagreement is latched when `cfg_dma` is set and REQ goes from low to high. `irq` is then high from the next cycle on. With `cfg_dma` clear, the same stimulus latches nothing.
- R4: A selection is latched and `irq` is raised when all three hold: BSY is low, SEL is high, and some data bit that is set in `sel_mask` is high. If BSY is high, or if no masked data bit is high, nothing is latched.
- R5: Parity is odd over the data bits and `bus_dbp`. It is checked at each low-to-high transition of REQ, and only while `cfg_par_chk` is set. A failure sets status bit 5. It reaches `irq` only when `cfg_par_irq` is set.
- R6: Any high-to-low transition of BSY sets status bit 2. It reaches `irq` only when `cfg_bsy_mon` is set.
- R7: A high `eop_in` sets status bit 7. It reaches `irq` only when `cfg_eop_irq` is set.
- R8: At address 5, `rd_data` returns the status byte with these bits, from 7 down to 0: end-of-DMA, DRQ, parity error, IRQ, phase match, busy error, ATN, ACK. Every other address returns zero.
- R9: A cycle with `rd_en` high and `rd_addr` equal to 7 clears all latched conditions, so `irq` drops in the next cycle. An event arriving in that same cycle stays latched.
- R10: `drq` equals `dma_req_in` AND `cfg_dma` AND NOT(phase disagreement latched).
- R11: `irq` is the OR of each latched condition ANDed with its enable. Raising an enable while its condition is already latched raises `irq` without any new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_bsy | input | 1 | BSY line, active high |
| bus_sel | input | 1 | SEL line |
| bus_req | input | 1 | REQ line |
| bus_ack | input | 1 | ACK line |
| bus_atn | input | 1 | ATN line |
| bus_msg | input | 1 | MSG line |
| bus_cd | input | 1 | C/D line |
| bus_io | input | 1 | I/O line |
| bus_data | input | DATA_W | Data lines |
| bus_dbp | input | 1 | Data parity line |
| cfg_dma | input | 1 | DMA mode active |
| cfg_par_chk | input | 1 | Parity checking enable |
| cfg_par_irq | input | 1 | Parity interrupt enable |
| cfg_eop_irq | input | 1 | End-of-process interrupt enable |
| cfg_bsy_mon | input | 1 | BSY-loss interrupt enable |
| exp_phase | input | 3 | Expected phase {MSG,C/D,I/O} |
| sel_mask | input | DATA_W | IDs this device answers to |
| dma_req_in | input | 1 | Raw request from the transfer engine |
| eop_in | input | 1 | End of process pulse |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data |
| irq | output | 1 | Interrupt request |
| drq | output | 1 | Gated DMA request |

## Verification
The hardest case to reach is a phase disagreement at a REQ edge. It needs DMA mode on, REQ held low for at least one sampled cycle, and then REQ raised while the live phase differs from the expected one. The bench programs a data-in expectation, leaves the bus lines at data-out and toggles REQ across two cycles, with DMA mode both off and on. It also sets an enable only after its condition has latched, and it issues a clear in the same cycle as a fresh end-of-process event, to show that the new event survives the clear.

// File: rtl/scsi_mon_pkg.sv
package scsi_mon_pkg;

    localparam int NUM_COND  = 5;
    localparam int CI_PHASE  = 0;
    localparam int CI_SEL    = 1;
    localparam int CI_PAR    = 2;
    localparam int CI_BSY    = 3;
    localparam int CI_EOP    = 4;

    typedef enum logic [2:0] {
        PH_DATA_OUT = 3'b000,
        PH_DATA_IN  = 3'b001,
        PH_COMMAND  = 3'b010,
        PH_STATUS   = 3'b011,
        PH_MSG_OUT  = 3'b110,
        PH_MSG_IN   = 3'b111
    } phase_e;

    typedef struct packed {
        logic msg;
        logic cd;
        logic io;
    } phase_bits_t;

    typedef struct packed {
        logic end_dma;
        logic drq;
        logic par_err;
        logic irq;
        logic phase_ok;
        logic bsy_err;
        logic atn;
        logic ack;
    } bsr_t;

    // Live phase lines placed where a status byte carries them (bits 4..2)
    function automatic logic [7:0] status_phase_byte(input phase_bits_t p);
        return {3'b000, p.msg, p.cd, p.io, 2'b00};
    endfunction

    // Two-place right shift brings the status field onto the command bits
    function automatic logic [2:0] align_to_cmd(input logic [7:0] sr);
        logic [7:0] s;
        s = sr >> 2;
        return s[2:0];
    endfunction

endpackage

// File: rtl/smon_phase_check.sv
module smon_phase_check
    import scsi_mon_pkg::*;
(
    input  phase_bits_t live,
    input  logic [2:0]  expected,
    input  logic        dma_on,
    input  logic        req_rise,
    output logic        phase_ok,
    output logic        mismatch_evt
);
    logic [7:0] status_view;
    logic [2:0] aligned;

    always_comb begin
        status_view  = status_phase_byte(live);
        aligned      = align_to_cmd(status_view);
        phase_ok     = (aligned == expected);
        mismatch_evt = dma_on && req_rise && !phase_ok;
    end
endmodule

// File: rtl/smon_event_detect.sv
module smon_event_detect #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bsy,
    input  logic              sel,
    input  logic              req,
    input  logic [DATA_W-1:0] data,
    input  logic              dbp,
    input  logic [DATA_W-1:0] id_mask,
    input  logic              par_chk,
    input  logic              eop,
    output logic              req_rise,
    output logic              sel_evt,
    output logic              par_evt,
    output logic              bsy_evt,
    output logic              eop_evt
);
    logic req_q;
    logic bsy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            bsy_q <= 1'b0;
        end else begin
            req_q <= req;
            bsy_q <= bsy;
        end
    end

    always_comb begin
        req_rise = req && !req_q;
        sel_evt  = !bsy && sel && (|(data & id_mask));
        par_evt  = par_chk && req_rise && !(^{data, dbp});
        bsy_evt  = bsy_q && !bsy;
        eop_evt  = eop;
    end
endmodule

// File: rtl/smon_cond_bank.sv
module smon_cond_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] en_vec,
    input  logic         clr,
    output logic [N-1:0] held,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_cond
        always_ff @(posedge clk) begin
            if (rst)
                held[i] <= 1'b0;
            else
                held[i] <= set_vec[i] | (held[i] & ~clr);
        end
    end

    assign irq = |(held & en_vec);
endmodule

// File: rtl/scsi_evt_monitor.sv
module scsi_evt_monitor
    import scsi_mon_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int STATUS_ADDR = 5,
    parameter int CLEAR_ADDR  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_bsy,
    input  logic              bus_sel,
    input  logic              bus_req,
    input  logic              bus_ack,
    input  logic              bus_atn,
    input  logic              bus_msg,
    input  logic              bus_cd,
    input  logic              bus_io,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_dbp,
    input  logic              cfg_dma,
    input  logic              cfg_par_chk,
    input  logic              cfg_par_irq,
    input  logic              cfg_eop_irq,
    input  logic              cfg_bsy_mon,
    input  logic [2:0]        exp_phase,
    input  logic [DATA_W-1:0] sel_mask,
    input  logic              dma_req_in,
    input  logic              eop_in,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              irq,
    output logic              drq
);
    localparam logic [ADDR_W-1:0] ST_A  = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLEAR_ADDR);

    phase_bits_t         live;
    logic                phase_ok, mismatch_evt, req_rise;
    logic                sel_evt, par_evt, bsy_evt, eop_evt;
    logic [NUM_COND-1:0] set_vec, en_vec, held;
    logic                clr_hit;
    bsr_t                bsr;

    assign live = '{msg: bus_msg, cd: bus_cd, io: bus_io};

    smon_event_detect #(.DATA_W(DATA_W)) u_evt (
        .clk     (clk),
        .rst     (rst),
        .bsy     (bus_bsy),
        .sel     (bus_sel),
        .req     (bus_req),
        .data    (bus_data),
        .dbp     (bus_dbp),
        .id_mask (sel_mask),
        .par_chk (cfg_par_chk),
        .eop     (eop_in),
        .req_rise(req_rise),
        .sel_evt (sel_evt),
        .par_evt (par_evt),
        .bsy_evt (bsy_evt),
        .eop_evt (eop_evt)
    );

    smon_phase_check u_ph (
        .live        (live),
        .expected    (exp_phase),
        .dma_on      (cfg_dma),
        .req_rise    (req_rise),
        .phase_ok    (phase_ok),
        .mismatch_evt(mismatch_evt)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[CI_PHASE] = mismatch_evt;
        set_vec[CI_SEL]   = sel_evt;
        set_vec[CI_PAR]   = par_evt;
        set_vec[CI_BSY]   = bsy_evt;
        set_vec[CI_EOP]   = eop_evt;
        en_vec            = '0;
        en_vec[CI_PHASE]  = 1'b1;
        en_vec[CI_SEL]    = 1'b1;
        en_vec[CI_PAR]    = cfg_par_irq;
        en_vec[CI_BSY]    = cfg_bsy_mon;
        en_vec[CI_EOP]    = cfg_eop_irq;
    end

    assign clr_hit = rd_en && (rd_addr == CLR_A);

    smon_cond_bank #(.N(NUM_COND)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .set_vec(set_vec),
        .en_vec (en_vec),
        .clr    (clr_hit),
        .held   (held),
        .irq    (irq)
    );

    assign drq = dma_req_in && cfg_dma && !held[CI_PHASE];

    always_comb begin
        bsr.end_dma  = held[CI_EOP];
        bsr.drq      = drq;
        bsr.par_err  = held[CI_PAR];
        bsr.irq      = irq;
        bsr.phase_ok = phase_ok;
        bsr.bsy_err  = held[CI_BSY];
        bsr.atn      = bus_atn;
        bsr.ack      = bus_ack;
        rd_data      = (rd_addr == ST_A) ? bsr : 8'h00;
    end
endmodule

// File: rtl/scsi_evt_monitor_chk.sv
module scsi_evt_monitor_chk #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int STATUS_ADDR = 5,
    parameter int CLEAR_ADDR  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_bsy,
    input logic              bus_sel,
    input logic              bus_req,
    input logic              bus_msg,
    input logic              bus_cd,
    input logic              bus_io,
    input logic [DATA_W-1:0] bus_data,
    input logic [DATA_W-1:0] sel_mask,
    input logic              cfg_dma,
    input logic              cfg_eop_irq,
    input logic              cfg_bsy_mon,
    input logic [2:0]        exp_phase,
    input logic              dma_req_in,
    input logic              eop_in,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic              irq,
    input logic              drq
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !irq);

    // R3
    phase_trip_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cfg_dma && $rose(bus_req) && ({bus_msg, bus_cd, bus_io} != exp_phase))
        |=> (irq && !drq));

    // R4
    select_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_bsy && bus_sel && (|(bus_data & sel_mask))) |=> irq);

    // R6
    bsy_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(bus_bsy) && cfg_bsy_mon) |=> irq);

    // R7
    eop_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (eop_in && cfg_eop_irq) |=> irq);

    // R9
    clear_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == ADDR_W'(CLEAR_ADDR) && bus_bsy && !bus_req && !eop_in)
        |=> !irq);

    // R10
    drq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        drq |-> (cfg_dma && dma_req_in));

    // R8
    idle_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr != ADDR_W'(STATUS_ADDR)) |-> (rd_data == 8'h00));
endmodule

bind scsi_evt_monitor scsi_evt_monitor_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .STATUS_ADDR(STATUS_ADDR), .CLEAR_ADDR(CLEAR_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .bus_bsy(bus_bsy), .bus_sel(bus_sel),
    .bus_req(bus_req), .bus_msg(bus_msg), .bus_cd(bus_cd), .bus_io(bus_io),
    .bus_data(bus_data), .sel_mask(sel_mask), .cfg_dma(cfg_dma),
    .cfg_eop_irq(cfg_eop_irq), .cfg_bsy_mon(cfg_bsy_mon),
    .exp_phase(exp_phase), .dma_req_in(dma_req_in), .eop_in(eop_in),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .drq(drq)
);

// File: tb/sim_scsi_evt_monitor.sv
`timescale 1ns/1ps
module sim_scsi_evt_monitor;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_bsy = 0, bus_sel = 0, bus_req = 0, bus_ack = 0, bus_atn = 0;
    logic bus_msg = 0, bus_cd = 0, bus_io = 0, bus_dbp = 0;
    logic [7:0] bus_data = 8'h00, sel_mask = 8'h00;
    logic cfg_dma = 0, cfg_par_chk = 0, cfg_par_irq = 0, cfg_eop_irq = 0, cfg_bsy_mon = 0;
    logic [2:0] exp_phase = 3'b000;
    logic dma_req_in = 0, eop_in = 0, rd_en = 0;
    logic [2:0] rd_addr = 3'd5;
    logic [7:0] rd_data;
    logic irq, drq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    scsi_evt_monitor u0 (
        .clk(clk), .rst(rst), .bus_bsy(bus_bsy), .bus_sel(bus_sel),
        .bus_req(bus_req), .bus_ack(bus_ack), .bus_atn(bus_atn),
        .bus_msg(bus_msg), .bus_cd(bus_cd), .bus_io(bus_io),
        .bus_data(bus_data), .bus_dbp(bus_dbp), .cfg_dma(cfg_dma),
        .cfg_par_chk(cfg_par_chk), .cfg_par_irq(cfg_par_irq),
        .cfg_eop_irq(cfg_eop_irq), .cfg_bsy_mon(cfg_bsy_mon),
        .exp_phase(exp_phase), .sel_mask(sel_mask), .dma_req_in(dma_req_in),
        .eop_in(eop_in), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .drq(drq)
    );

    // {live MSG,C/D,I/O ; expected ; match}
    localparam logic [6:0] PH_VEC [8] = '{
        7'b000_000_1, 7'b001_000_0, 7'b010_010_1, 7'b011_011_1,
        7'b110_111_0, 7'b111_111_1, 7'b110_110_1, 7'b001_011_0
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic status(output logic [7:0] v);
        rd_addr = 3'd5;
        #1;
        v = rd_data;
    endtask

    task automatic clear_all();
        rd_en = 1'b1;
        rd_addr = 3'd7;
        tick();
        rd_en = 1'b0;
        rd_addr = 3'd5;
        #1;
    endtask

    initial begin
        #1600000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        status(v);
        chk("R1 status after reset", v, 8'h08);
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);

        // R2 phase compare table
        for (int i = 0; i < 8; i++) begin
            {bus_msg, bus_cd, bus_io} = PH_VEC[i][6:4];
            exp_phase = PH_VEC[i][3:1];
            status(v);
            chk($sformatf("R2 vector %0d", i), {7'd0, v[3]}, {7'd0, PH_VEC[i][0]});
        end
        {bus_msg, bus_cd, bus_io} = 3'b000;
        exp_phase = 3'b001;

        // R3 without DMA: no latch
        bus_req = 1'b1; tick(); bus_req = 1'b0; tick(); #1;
        chk("R3 no dma no irq", {7'd0, irq}, 8'h00);
        // R10 drq passes
        cfg_dma = 1'b1; dma_req_in = 1'b1; #1;
        chk("R10 drq open", {7'd0, drq}, 8'h01);
        // R3 mismatch in DMA
        bus_req = 1'b1; tick(); #1;
        chk("R3 mismatch irq", {7'd0, irq}, 8'h01);
        chk("R10 drq blocked", {7'd0, drq}, 8'h00);
        status(v);
        chk("R8 status drq/irq bits", v, 8'h10);
        bus_req = 1'b0;
        clear_all();
        chk("R9 irq cleared", {7'd0, irq}, 8'h00);
        chk("R10 drq reopened", {7'd0, drq}, 8'h01);
        // R3 matching phase in DMA: no latch
        exp_phase = 3'b000;
        tick();
        bus_req = 1'b1; tick(); bus_req = 1'b0; #1;
        chk("R3 matched phase no irq", {7'd0, irq}, 8'h00);
        cfg_dma = 1'b0; dma_req_in = 1'b0;

        // R4 selection
        sel_mask = 8'h20; bus_data = 8'h20; bus_sel = 1'b1;
        tick(); #1;
        chk("R4 select irq", {7'd0, irq}, 8'h01);
        bus_sel = 1'b0; bus_data = 8'h00; tick();
        clear_all();
        bus_data = 8'h10; bus_sel = 1'b1; tick(); #1;
        chk("R4 foreign id ignored", {7'd0, irq}, 8'h00);
        bus_bsy = 1'b1; bus_data = 8'h20; tick(); #1;
        chk("R4 bsy high ignored", {7'd0, irq}, 8'h00);
        bus_sel = 1'b0; bus_data = 8'h00; bus_bsy = 1'b0; tick();
        clear_all();

        // R5 parity
        cfg_par_chk = 1'b1; bus_data = 8'h03; bus_dbp = 1'b0;
        bus_req = 1'b1; tick(); bus_req = 1'b0;
        status(v);
        chk("R5 parity flag", v & 8'h30, 8'h20);
        cfg_par_irq = 1'b1; #1;
        chk("R11 late enable raises irq", {7'd0, irq}, 8'h01);
        tick();
        clear_all();
        bus_dbp = 1'b1; bus_req = 1'b1; tick(); bus_req = 1'b0;
        status(v);
        chk("R5 good parity clean", v & 8'h20, 8'h00);
        tick();
        cfg_par_chk = 1'b0; bus_dbp = 1'b0; bus_req = 1'b1; tick(); bus_req = 1'b0;
        status(v);
        chk("R5 check disabled", v & 8'h20, 8'h00);
        cfg_par_irq = 1'b0; bus_data = 8'h00; tick();

        // R6 busy loss
        bus_bsy = 1'b1; tick(); bus_bsy = 1'b0; tick();
        status(v);
        chk("R6 bsy flag no irq", v & 8'h14, 8'h04);
        clear_all();
        cfg_bsy_mon = 1'b1;
        bus_bsy = 1'b1; tick(); bus_bsy = 1'b0; tick(); #1;
        chk("R6 monitored irq", {7'd0, irq}, 8'h01);
        clear_all();
        cfg_bsy_mon = 1'b0;

        // R7 end of process
        eop_in = 1'b1; tick(); eop_in = 1'b0;
        status(v);
        chk("R7 eop flag no irq", v & 8'h90, 8'h80);
        cfg_eop_irq = 1'b1; #1;
        chk("R7 eop irq enabled", {7'd0, irq}, 8'h01);
        clear_all();
        chk("R9 eop cleared", {7'd0, irq}, 8'h00);

        // R9 event in the same cycle as clear survives
        eop_in = 1'b1; rd_en = 1'b1; rd_addr = 3'd7; tick();
        eop_in = 1'b0; rd_en = 1'b0;
        status(v);
        chk("R9 same-cycle event kept", v & 8'h80, 8'h80);
        clear_all();
        status(v);
        chk("R9 later clear", v & 8'h80, 8'h00);
        cfg_eop_irq = 1'b0;

        // R8 live lines and other addresses
        bus_atn = 1'b1; bus_ack = 1'b1;
        status(v);
        chk("R8 atn ack bits", v & 8'h03, 8'h03);
        rd_addr = 3'd3; #1;
        chk("R8 other address zero", rd_data, 8'h00);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule